// File: doc/BRIEF.md
# Serial Port Interrupt Enable and Status Controller

This block gathers thirteen event pulses from a serial port (receive and transmit FIFO level flags, receive errors, a receive timeout and a modem-line change) into one level-sensitive interrupt line. Each event sets a sticky status bit. Software removes a status bit by writing a one to it. Whether a status bit can raise the interrupt depends on a mask. The mask cannot be written directly. One offset sets mask bits and another offset clears them, so two software contexts never have to read, modify and write the same word.

Software reaches the registers through a single-cycle request port with valid, write, byte offset and write data signals. A read returns its data one cycle later, together with a valid pulse. The interrupt output is high whenever any status bit is set together with its mask bit. Status bits latch whether or not they are masked. A driver that wants a fresh edge from a level-type source, such as transmit-empty, therefore clears that source's stale status bit before it enables the source.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset, the mask and status registers read zero, `irq_o` is low and `rd_valid_o` is low.
- R2: A write to offset 0x08 sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to offset 0x0C clears each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: The mask reads back at offset 0x10. A write to 0x10 leaves the mask unchanged, and the mask changes only through writes to 0x08 or 0x0C.
- R5: Once a status bit is set, it stays set after its event pulse ends. It is cleared only by a clear write that has a 1 at its position.
- R6: An event pulse sets its status bit in the next cycle, whether or not the matching mask bit is set.
- R7: A write to offset 0x14 clears each status bit whose write-data bit is 1 and leaves the other status bits alone. Writing 0x1FFF clears all thirteen.
- R8: When an event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when some bit is set in both status and mask. It follows a register update without an added cycle.
- R10: A read request returns `rd_data_o` with `rd_valid_o` high in the cycle after the request, for one cycle only. Bits 31..13 read zero. Offsets other than 0x10 and 0x14 read zero.
- R11: Source bit positions, from bit 0 to bit 12: rx trigger, rx empty, rx full, tx empty, tx full, rx overflow, framing error, parity error, rx timeout, modem status change, tx trigger, tx nearly full, tx overflow. Event input bit i maps to status and mask bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rd_data_o | output | 32 | Read data |
| evt_i | input | 13 | Event pulses, one per source |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `evt_i` and all request inputs are quiet while reset is held. They also assume that each request lasts exactly one cycle, so a write is counted once. The bench drives every input on the falling clock edge, holds events low during reset and drops `req_valid_i` after each single-cycle request. The event-wins case is exercised by driving an event and a clear of the same bit in one cycle. Unused offsets are probed only with reads, so no assertion sees a write outside the decoded map.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int NUM_SRC = 13;

  // register byte offsets
  localparam logic [7:0] OFS_ENABLE  = 8'h08;
  localparam logic [7:0] OFS_DISABLE = 8'h0C;
  localparam logic [7:0] OFS_MASK    = 8'h10;
  localparam logic [7:0] OFS_STATUS  = 8'h14;

  // source bit positions
  localparam int SRC_RX_TRIG   = 0;
  localparam int SRC_RX_EMPTY  = 1;
  localparam int SRC_RX_FULL   = 2;
  localparam int SRC_TX_EMPTY  = 3;
  localparam int SRC_TX_FULL   = 4;
  localparam int SRC_RX_OVF    = 5;
  localparam int SRC_FRAME_ERR = 6;
  localparam int SRC_PAR_ERR   = 7;
  localparam int SRC_RX_TOUT   = 8;
  localparam int SRC_MODEM_CHG = 9;
  localparam int SRC_TX_TRIG   = 10;
  localparam int SRC_TX_NFULL  = 11;
  localparam int SRC_TX_OVF    = 12;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_MASK   = 2'd1,
    RSEL_STATUS = 2'd2
  } rd_sel_e;

endpackage

// File: rtl/sio_irq_decode.sv
module sio_irq_decode
  import sio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              set_we_o,
  output logic              clr_mask_we_o,
  output logic              clr_sts_we_o,
  output logic              rd_req_o,
  output rd_sel_e           rd_sel_o
);

  logic wr_req;

  always_comb begin
    wr_req        = valid_i && write_i;
    rd_req_o      = valid_i && !write_i;
    set_we_o      = wr_req && (addr_i == ADDR_W'(OFS_ENABLE));
    clr_mask_we_o = wr_req && (addr_i == ADDR_W'(OFS_DISABLE));
    clr_sts_we_o  = wr_req && (addr_i == ADDR_W'(OFS_STATUS));
    if (addr_i == ADDR_W'(OFS_MASK)) begin
      rd_sel_o = RSEL_MASK;
    end else if (addr_i == ADDR_W'(OFS_STATUS)) begin
      rd_sel_o = RSEL_STATUS;
    end else begin
      rd_sel_o = RSEL_NONE;
    end
  end

endmodule

// File: rtl/sio_irq_mask.sv
module sio_irq_mask #(
  parameter int WIDTH = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] bits_i,
  output logic [WIDTH-1:0] mask_o
);

  logic [WIDTH-1:0] mask_d, mask_q;
  logic             mask_en;

  always_comb begin
    mask_en = set_we_i || clr_we_i;
    mask_d  = mask_q;
    if (set_we_i) begin
      mask_d = mask_d | bits_i;
    end
    if (clr_we_i) begin
      mask_d = mask_d & ~bits_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/sio_irq_status.sv
module sio_irq_status #(
  parameter int WIDTH = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_bits_i,
  input  logic [WIDTH-1:0] evt_i,
  output logic [WIDTH-1:0] sts_o
);

  logic [WIDTH-1:0] sts_d, sts_q, clr_eff;
  logic             sts_en;

  always_comb begin
    clr_eff = clr_we_i ? clr_bits_i : '0;
    sts_en  = clr_we_i || (|evt_i);
    // an event in the same cycle overrides the clear
    sts_d   = (sts_q & ~clr_eff) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  assign sts_o = sts_q;

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SRC_W  = NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [SRC_W-1:0]  evt_i,
  output logic              irq_o
);

  localparam int PAD_W = DATA_W - SRC_W;

  logic             set_we, clr_mask_we, clr_sts_we, rd_req;
  rd_sel_e          rd_sel;
  logic [SRC_W-1:0] wbits, mask_q, sts_q, rd_src;
  logic             rd_valid_d, rd_valid_q;
  logic [DATA_W-1:0] rd_data_d, rd_data_q;
  logic             unused_wdata_hi;

  assign wbits           = req_wdata_i[SRC_W-1:0];
  assign unused_wdata_hi = ^req_wdata_i[DATA_W-1:SRC_W];

  sio_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid_i       (req_valid_i),
    .write_i       (req_write_i),
    .addr_i        (req_addr_i),
    .set_we_o      (set_we),
    .clr_mask_we_o (clr_mask_we),
    .clr_sts_we_o  (clr_sts_we),
    .rd_req_o      (rd_req),
    .rd_sel_o      (rd_sel)
  );

  sio_irq_mask #(.WIDTH(SRC_W)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_we_i (set_we),
    .clr_we_i (clr_mask_we),
    .bits_i   (wbits),
    .mask_o   (mask_q)
  );

  sio_irq_status #(.WIDTH(SRC_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_we_i   (clr_sts_we),
    .clr_bits_i (wbits),
    .evt_i      (evt_i),
    .sts_o      (sts_q)
  );

  // read path: next state
  always_comb begin
    unique case (rd_sel)
      RSEL_MASK:   rd_src = mask_q;
      RSEL_STATUS: rd_src = sts_q;
      default:     rd_src = '0;
    endcase
    rd_valid_d = rd_req;
    rd_data_d  = {{PAD_W{1'b0}}, rd_src};
  end

  // read path: registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
    end else if (rd_req) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign irq_o      = |(sts_q & mask_q);

endmodule

// File: rtl/sio_irq_ctrl_chk.sv
module sio_irq_ctrl_chk
  import sio_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SRC_W  = NUM_SRC
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [SRC_W-1:0]  evt_i,
  input logic              irq_o,
  input logic [SRC_W-1:0]  mask_q,
  input logic [SRC_W-1:0]  sts_q
);

  logic             wr_en, wr_dis, wr_clr, rd_req;
  logic [SRC_W-1:0] bits, clr_bits;

  always_comb begin
    wr_en    = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(OFS_ENABLE));
    wr_dis   = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(OFS_DISABLE));
    wr_clr   = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(OFS_STATUS));
    rd_req   = req_valid_i && !req_write_i;
    bits     = req_wdata_i[SRC_W-1:0];
    clr_bits = wr_clr ? bits : '0;
  end

  assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (($past(bits) & ~mask_q) == '0));

  assert_mask_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis |=> (($past(bits) & mask_q) == '0));

  assert_mask_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en || wr_dis) |=> $stable(mask_q));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sts_q) |=> ((($past(sts_q) & ~sts_q) & ~$past(clr_bits)) == '0));

  assert_evt_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> (($past(evt_i) & ~sts_q) == '0));

  // R8: same-cycle clear must not undo an event
  assert_evt_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && |(evt_i & bits)) |=> (($past(evt_i) & ~sts_q) == '0));

  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|evt_i) || $past(wr_en)));

  assert_rd_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rd_valid_o);

  assert_rd_only_after_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rd_valid_o);

  assert_rd_hi_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_data_o[DATA_W-1:SRC_W] == '0));

endmodule

bind sio_irq_ctrl sio_irq_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .SRC_W  (SRC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .evt_i       (evt_i),
  .irq_o       (irq_o),
  .mask_q      (mask_q),
  .sts_q       (sts_q)
);

// File: tb/sio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module sio_irq_ctrl_bench;
  import sio_irq_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;
  logic [12:0] evt_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [12:0] m_mask = '0;
  logic [12:0] m_sts  = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;

  sio_irq_ctrl u_sio_irq_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .evt_i       (evt_i),
    .irq_o       (irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-cycle write, optional events in the same cycle
  task automatic bus_wr(input logic [7:0] a, input logic [12:0] d, input logic [12:0] ev);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a;
    req_wdata_i = {19'h7FFFF, d}; evt_i = ev;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0; evt_i = '0;
    if (a == OFS_ENABLE)  m_mask = m_mask | d;
    if (a == OFS_DISABLE) m_mask = m_mask & ~d;
    if (a == OFS_STATUS)  m_sts  = (m_sts & ~d) | ev;
    else                  m_sts  = m_sts | ev;
  endtask

  task automatic pulse(input logic [12:0] ev);
    @(negedge clk_i);
    evt_i = ev;
    @(negedge clk_i);
    evt_i = '0;
    m_sts = m_sts | ev;
  endtask

  // driver: push expected read result into the scoreboard
  task automatic bus_rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
    if (a == OFS_MASK)        e = {19'b0, m_mask};
    else if (a == OFS_STATUS) e = {19'b0, m_sts};
    else                      e = '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    check(tag, {31'b0, irq_o}, {31'b0, |(m_sts & m_mask)});
  endtask

  // monitor: pop and compare as read results appear
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (rst_ni && rd_valid_o) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R10 unexpected rd_valid actual=1 expected=0");
        end else begin
          check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 32'd0);
    check("R1 rd_valid", {31'b0, rd_valid_o}, 32'd0);
    bus_rd(OFS_MASK, "R1 mask");
    bus_rd(OFS_STATUS, "R1 status");

    // R2 enable
    bus_wr(OFS_ENABLE, 13'h0005, '0);
    bus_rd(OFS_MASK, "R2 mask set");
    bus_wr(OFS_ENABLE, 13'h0002, '0);
    bus_rd(OFS_MASK, "R2 zeros keep");
    // R4 write to mask view ignored
    bus_wr(OFS_MASK, 13'h1FFF, '0);
    bus_rd(OFS_MASK, "R4 mask write ignored");
    // R3 disable
    bus_wr(OFS_DISABLE, 13'h0001, '0);
    bus_rd(OFS_MASK, "R3 mask clr");

    // R6/R11 unmasked tx-empty event latches at bit 3
    pulse(13'(1 << SRC_TX_EMPTY));
    bus_rd(OFS_STATUS, "R6 R11 unmasked latch");
    chk_irq("R9 masked no irq");
    // R9 masked-in event raises irq
    pulse(13'(1 << SRC_RX_EMPTY));
    chk_irq("R9 irq high");
    repeat (4) @(negedge clk_i);
    bus_rd(OFS_STATUS, "R5 sticky");
    // R7 partial clear
    bus_wr(OFS_STATUS, 13'h0002, '0);
    bus_rd(OFS_STATUS, "R7 partial clear");
    chk_irq("R9 irq low after clear");
    // R8 event wins
    bus_wr(OFS_STATUS, 13'(1 << SRC_RX_OVF), 13'(1 << SRC_RX_OVF));
    bus_rd(OFS_STATUS, "R8 event wins");
    // R7 all set then all clear
    pulse(13'h1FFF);
    bus_rd(OFS_STATUS, "R6 all set");
    bus_wr(OFS_STATUS, 13'h1FFF, '0);
    bus_rd(OFS_STATUS, "R7 clear all");
    chk_irq("R9 irq low empty");
    // R10 other offsets read zero, valid lasts one cycle
    bus_rd(OFS_ENABLE, "R10 enable reads zero");
    bus_rd(8'h24, "R10 unmapped reads zero");
    @(negedge clk_i);
    check("R10 valid one cycle", {31'b0, rd_valid_o}, 32'd0);

    // R11 each source drives irq through its own bit
    bus_wr(OFS_DISABLE, 13'h1FFF, '0);
    for (int i = 0; i < 13; i++) begin
      bus_wr(OFS_ENABLE, 13'(1 << i), '0);
      chk_irq("R9 irq before event");
      pulse(13'(1 << i));
      chk_irq("R11 source irq");
      bus_rd(OFS_STATUS, "R11 source bit");
      bus_wr(OFS_DISABLE, 13'(1 << i), '0);
      chk_irq("R3 disable drops irq");
      bus_wr(OFS_STATUS, 13'(1 << i), '0);
    end

    repeat (3) @(negedge clk_i);
    check("R10 scoreboard drained", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule